// File: doc/BRIEF.md
# Keypad pattern match interrupt

This block watches an 8-bit input port, such as a row of keys, and raises a sticky flag when the port shows a chosen condition for long enough. A mask register selects which pins take part. A pattern register holds the reference value. A select bit chooses the condition. With the select bit at 0, the condition is that the masked port equals the masked pattern. With the select bit at 1, the condition is that the two differ. The condition must hold for more than a set number of clocks in a row before the flag sets. This filters out glitches and key bounce.

The flag drives an interrupt request when the interrupt enable is set. It drives a wake-up output when the wake enable is set. Software sets up the registers and clears the flag through a small write-only register port. A common setup is pattern 0xFF with not-equal selected. In that setup, pulling any enabled key low sets the flag, so the block acts as an any-key interrupt. Port pins pass through a synchroniser before the comparison.

Top module: `kpd_match_irq`

## Requirements
- R1: After reset, flag_o, irq_o and wake_o are 0. The register reset values are mask 0x00, pattern 0x00 and all control bits 0.
- R2: Port bits whose mask bit is 0 have no effect on the condition.
- R3: With select bit 0 (control bit 0), the condition is true when the masked port equals the masked pattern.
- R4: With select bit 1, the condition is true when the masked port differs from the masked pattern.
- R5: The flag sets only after the condition has held for 7 clocks in a row, which is more than 6. A port value applied before a clock edge sets flag_o on the 9th rising edge: 2 synchroniser stages plus 7 qualifying clocks. A hold of 6 clocks does not set the flag.
- R6: When the condition drops for a single clock, the qualification count restarts from zero.
- R7: irq_o equals flag_o AND the interrupt enable (control bit 2).
- R8: wake_o equals flag_o AND the wake enable (control bit 3).
- R9: Register writes use the address on reg_addr_i: 0 for mask, 1 for pattern, 2 for control. The flag stays set until a control write with bit 1 equal to 0 clears it. Writing 1 to that bit has no effect.
- R10: A clear while the condition is still qualified drops the flag for exactly one clock. The flag then sets again.
- R11: With pattern 0xFF and not-equal selected, driving any enabled pin low sets the flag. A low pin outside the mask does not set it.
- R12: With a mask of 0x00, the flag never sets, in either mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_i | input | 8 | Asynchronous port pins |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 mask, 1 pattern, 2 control |
| reg_wdata_i | input | 8 | Write data |
| flag_o | output | 1 | Sticky match flag |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake-up request |

## Verification
The hardest case to reach is a clear that arrives while the condition is still qualified. The stimulus holds a matching port value past the threshold. It then issues the clear write and samples the flag at two points: low in the cycle after the write edge, and high again one clock later. The exact threshold is also hard to hit. The stimulus drives holds of exactly 6 and 7 clocks, and a 6-1-6 pattern with a one-clock gap. Each hold is timed from the clock edge where the port changes, counting the synchroniser stages.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_MASK = 2'd0,
    ADDR_PATN = 2'd1,
    ADDR_CTRL = 2'd2
  } kpd_addr_e;

  localparam int unsigned CTRL_SEL_NE  = 0;
  localparam int unsigned CTRL_FLAG    = 1;
  localparam int unsigned CTRL_IRQ_EN  = 2;
  localparam int unsigned CTRL_WAKE_EN = 3;

  typedef struct packed {
    logic sel_ne;
    logic irq_en;
    logic wake_en;
  } kpd_ctrl_t;
endpackage

// File: rtl/kpd_sync.sv
module kpd_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/kpd_regs.sv
module kpd_regs
  import kpd_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  mask_o,
  output logic [WIDTH-1:0]  patn_o,
  output kpd_ctrl_t         ctrl_o,
  output logic              clr_o
);
  logic wr_mask, wr_patn, wr_ctrl;

  assign wr_mask = we_i && (addr_i == ADDR_MASK);
  assign wr_patn = we_i && (addr_i == ADDR_PATN);
  assign wr_ctrl = we_i && (addr_i == ADDR_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '0;
      patn_o <= '0;
      ctrl_o <= '0;
    end else begin
      if (wr_mask) mask_o <= wdata_i;
      if (wr_patn) patn_o <= wdata_i;
      if (wr_ctrl) begin
        ctrl_o.sel_ne  <= wdata_i[CTRL_SEL_NE];
        ctrl_o.irq_en  <= wdata_i[CTRL_IRQ_EN];
        ctrl_o.wake_en <= wdata_i[CTRL_WAKE_EN];
      end
    end
  end

  // only a written zero clears; a one leaves the flag alone
  assign clr_o = wr_ctrl && !wdata_i[CTRL_FLAG];
endmodule

// File: rtl/kpd_qual.sv
module kpd_qual #(
  parameter int unsigned WIDTH    = 8,
  parameter int unsigned HOLD_CYC = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] port_i,
  input  logic [WIDTH-1:0] mask_i,
  input  logic [WIDTH-1:0] patn_i,
  input  logic             sel_ne_i,
  input  logic             clr_i,
  output logic             flag_o
);
  localparam int unsigned QUAL  = HOLD_CYC + 1;
  localparam int unsigned CNT_W = $clog2(QUAL + 1);

  logic [WIDTH-1:0] diff;
  logic             hit, cond, flag_set;
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;

  assign diff = (port_i ^ patn_i) & mask_i;
  assign hit  = sel_ne_i ? (|diff) : ~(|diff);
  assign cond = (|mask_i) && hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!cond)                  cnt_q <= '0;
    else if (cnt_q != CNT_W'(QUAL))  cnt_q <= cnt_q + 1'b1;
  end

  assign flag_set = cond && (cnt_q >= CNT_W'(QUAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (clr_i)    flag_q <= 1'b0;
    else if (flag_set) flag_q <= 1'b1;
  end

  assign flag_o = flag_q;

  AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cond |=> (cnt_q == '0)); // R6
  AST_FLAG_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(cond) && ($past(cnt_q) >= CNT_W'(QUAL - 1))); // R5
  AST_CLEAR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !flag_q); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q); // R9
  AST_EMPTY_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |=> (cnt_q == '0)); // R12
endmodule

// File: rtl/kpd_match_irq.sv
module kpd_match_irq
  import kpd_pkg::*;
#(
  parameter int unsigned PORT_W      = 8,
  parameter int unsigned HOLD_CYC    = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PORT_W-1:0] port_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [PORT_W-1:0] reg_wdata_i,
  output logic              flag_o,
  output logic              irq_o,
  output logic              wake_o
);
  logic [PORT_W-1:0] port_s, mask, patn;
  kpd_ctrl_t         ctrl;
  logic              clr, flag;

  kpd_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (port_i),
    .q_o   (port_s)
  );

  kpd_regs #(.WIDTH(PORT_W)) i_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .mask_o (mask),
    .patn_o (patn),
    .ctrl_o (ctrl),
    .clr_o  (clr)
  );

  kpd_qual #(.WIDTH(PORT_W), .HOLD_CYC(HOLD_CYC)) i_qual (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .port_i  (port_s),
    .mask_i  (mask),
    .patn_i  (patn),
    .sel_ne_i(ctrl.sel_ne),
    .clr_i   (clr),
    .flag_o  (flag)
  );

  assign flag_o = flag;
  assign irq_o  = flag & ctrl.irq_en;
  assign wake_o = flag & ctrl.wake_en;

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_o && ctrl.irq_en)); // R7
  AST_WAKE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (flag_o && ctrl.wake_en)); // R8
endmodule

// File: tb/test_kpd_match_irq.sv
module test_kpd_match_irq;
  localparam time CLK_PERIOD = 10ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] port_i = 8'h00;
  logic       reg_we_i = 1'b0;
  logic [1:0] reg_addr_i = 2'd0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic       flag_o, irq_o, wake_o;

  int n_vec = 0;
  int n_err = 0;
  bit done = 1'b0;

  kpd_match_irq i_kpd_match_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .port_i(port_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .flag_o(flag_o), .irq_o(irq_o), .wake_o(wake_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      @(negedge clk_i);
    end
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] addr, input logic [7:0] data);
    reg_we_i = 1'b1; reg_addr_i = addr; reg_wdata_i = data;
    tick(1);
    reg_we_i = 1'b0;
  endtask

  task automatic do_reset(input logic [7:0] idle);
    @(negedge clk_i);
    port_i = idle;
    rst_ni = 1'b0;
    tick(2);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset;
    do_reset(8'h00);
    check("R1 flag", flag_o, 0);
    check("R1 irq", irq_o, 0);
    check("R1 wake", wake_o, 0);
    tick(20);
    check("R12 empty mask equal", flag_o, 0);
    wr(2, 8'h01);
    port_i = 8'h5A;
    tick(20);
    check("R12 empty mask noteq", flag_o, 0);
  endtask

  task automatic t_equal;
    do_reset(8'h00);
    wr(1, 8'h05); wr(0, 8'h0F); wr(2, 8'h06);
    tick(12);
    check("R3 no match", flag_o, 0);
    port_i = 8'h05;
    tick(8);
    check("R5 before edge 9", flag_o, 0);
    tick(1);
    check("R3 R5 flag at edge 9", flag_o, 1);
    check("R7 irq enabled", irq_o, 1);
    check("R8 wake disabled", wake_o, 0);
  endtask

  task automatic t_unmasked;
    do_reset(8'h00);
    wr(1, 8'h05); wr(0, 8'h0F); wr(2, 8'h00);
    port_i = 8'h50;
    tick(12);
    check("R2 masked bits differ", flag_o, 0);
    check("R7 irq disabled", irq_o, 0);
    for (int i = 0; i < 9; i++) begin
      port_i = {4'(i * 3), 4'h5};
      tick(1);
    end
    check("R2 unmasked toggling", flag_o, 1);
    check("R7 irq gated", irq_o, 0);
  endtask

  task automatic t_noteq;
    do_reset(8'h3C);
    wr(1, 8'h3C); wr(0, 8'hFF); wr(2, 8'h0B);
    tick(12);
    check("R4 equal gives none", flag_o, 0);
    port_i = 8'h3D;
    tick(9);
    check("R4 differ sets", flag_o, 1);
    check("R8 wake enabled", wake_o, 1);
    check("R7 irq off", irq_o, 0);
  endtask

  task automatic t_threshold;
    do_reset(8'h00);
    wr(1, 8'h05); wr(0, 8'hFF); wr(2, 8'h06);
    tick(4);
    port_i = 8'h05; tick(6); port_i = 8'h00;
    tick(12);
    check("R5 six clocks", flag_o, 0);
    port_i = 8'h05; tick(6); port_i = 8'h00; tick(1);
    port_i = 8'h05; tick(6); port_i = 8'h00;
    tick(12);
    check("R6 restart after gap", flag_o, 0);
    port_i = 8'h05; tick(7); port_i = 8'h00;
    tick(2);
    check("R5 seven clocks", flag_o, 1);
  endtask

  task automatic t_clear;
    do_reset(8'h00);
    wr(1, 8'h05); wr(0, 8'hFF); wr(2, 8'h06);
    port_i = 8'h05; tick(7); port_i = 8'h00;
    tick(2);
    check("R9 set", flag_o, 1);
    tick(5);
    check("R9 held", flag_o, 1);
    wr(2, 8'h06);
    check("R9 write one no clear", flag_o, 1);
    wr(3, 8'h00);
    check("R9 unmapped addr no clear", flag_o, 1);
    wr(2, 8'h04);
    check("R9 cleared", flag_o, 0);
    check("R9 irq cleared", irq_o, 0);
    tick(5);
    check("R9 stays clear", flag_o, 0);
    port_i = 8'h05;
    tick(12);
    check("R10 set again", flag_o, 1);
    wr(2, 8'h04);
    check("R10 low one cycle", flag_o, 0);
    tick(1);
    check("R10 reasserted", flag_o, 1);
  endtask

  task automatic t_anykey;
    do_reset(8'hFF);
    wr(1, 8'hFF); wr(0, 8'h0F); wr(2, 8'h0D);
    tick(12);
    check("R11 idle", flag_o, 0);
    port_i = 8'h7F;
    tick(12);
    check("R11 masked key ignored", flag_o, 0);
    port_i = 8'hFB;
    tick(9);
    check("R11 key low sets", flag_o, 1);
    check("R11 irq", irq_o, 1);
    check("R11 wake", wake_o, 1);
  endtask

  initial begin
    t_reset();
    t_equal();
    t_unmasked();
    t_noteq();
    t_threshold();
    t_clear();
    t_anykey();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      n_vec++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end
endmodule